// File: doc/BRIEF.md
# Vectored Interrupt Address Generator

This block builds the 16-bit address of the vector-table entry that a processor core fetches when it accepts a maskable interrupt. The upper byte always comes from an 8-bit page register. The core loads and reads this register through its own transfer strobe, not through I/O cycles, so the table can be placed on any 256-byte boundary of a 64 KB space. The lower byte depends on which source wins. For the top-priority external line it is a vector the interrupting device places on the data bus. For every other source it is three programmable bits from a low-vector register joined to a five-bit code fixed for that source.

Request inputs are three external lines and a parameterised set of internal peripheral lines. A control register on the I/O bus enables each external line on its own. A global enable gates all sources. The block shows the core whether any enabled request is pending. When the core raises its acknowledge strobe, the block picks the winner by fixed priority. On the next cycle it presents the table address with a one-cycle valid flag, and sends a one-cycle acknowledge pulse to the chosen source.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset the page register is 00H, the low-vector register reads 00H at I/O address 33H, the control register reads 01H at I/O address 34H (only the first external line enabled), and `vec_valid` and every acknowledge output are low.
- R2: A cycle with `page_wr` high loads `page_wdata` into the page register, which appears on `page_rdata` after that edge; I/O writes at any address leave the page register unchanged.
- R3: An I/O write to address 33H stores data bits 7:5 in the low-vector register; reads of 33H return those bits in 7:5 with bits 4:0 always zero.
- R4: An I/O write to address 34H stores data bits 2:0 as the enables of external lines 0, 1 and 2 (bit n enables line n); reads of 34H return them in bits 2:0 with bits 7:3 zero; I/O writes to any other address change neither register, and reads of other addresses return 00H.
- R5: `int_req` is high, with no clock delay, exactly when at least one request line is both raised and enabled.
- R6: If `ack_req` is high at a clock edge while `int_req` is high, `vec_valid` is high for the following cycle only, and `vec_addr[15:8]` then equals the page register value before that edge.
- R7: When external line 0 wins, `vec_addr[7:0]` equals `bus_vec` as sampled at the acknowledge edge.
- R8: When any other source wins, `vec_addr[7:5]` is the stored low-vector field and `vec_addr[4:0]` is its code: external line 1 is 00000, external line 2 is 00010, and internal line k is 2k+4; bit 0 is always zero.
- R9: Priority is fixed: external 0, then external 1, then external 2, then internal lines in ascending index.
- R10: In the cycle `vec_valid` is high, exactly one bit of `{src_ack_int, src_ack_ext}` is high, the bit of the winning source; an acknowledge with no enabled request gives neither a valid nor any acknowledge pulse.
- R11: With `gie` low no source is enabled. An external line whose control bit is clear is never enabled. A masked source neither raises `int_req` nor wins arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_wr | input | 1 | Register-transfer strobe loading the page register |
| page_wdata | input | 8 | Data for the page register |
| page_rdata | output | 8 | Current page register value |
| io_addr | input | 8 | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, zero when not reading |
| gie | input | 1 | Global interrupt enable |
| irq_ext | input | 3 | External request lines 0..2 |
| irq_int | input | N_INT | Internal peripheral request lines |
| int_req | output | 1 | An enabled request is pending |
| ack_req | input | 1 | Core acknowledge strobe |
| bus_vec | input | 8 | Vector on the data bus for external line 0 |
| vec_addr | output | 16 | Vector-table entry address |
| vec_valid | output | 1 | `vec_addr` valid for this cycle |
| src_ack_ext | output | 3 | Acknowledge pulse to external lines |
| src_ack_int | output | N_INT | Acknowledge pulse to internal lines |

## Verification
A corrupted page register shows up in the high address byte on the first acknowledge after the corruption. `page_rdata` shows it on the same edge. A low-vector field or enable bit stored wrongly shows up on the next I/O read of its address. It also shows up on the next acknowledge, as a wrong bits 7:5 or a masked source that wins. A wrong winner shows up one cycle after the acknowledge edge, both as an unexpected low-byte code and as an acknowledge pulse on the wrong line. The bench forces these cases with overlapping requests, masked lines and changes to the page register between acknowledges.

// File: rtl/vag_pkg.sv
`timescale 1ns/1ps
package vag_pkg;
  localparam int          EXT_N     = 3;
  localparam logic [7:0]  IO_LOWVEC = 8'h33;
  localparam logic [7:0]  IO_CTRL   = 8'h34;
  localparam logic [2:0]  CTRL_RST  = 3'b001;

  // Fixed five-bit code for source index src (src >= 1); even, word aligned.
  function automatic logic [4:0] src_code(input int unsigned src);
    return 5'((src - 1) * 2);
  endfunction

  // Low byte of the table address for a given winner.
  function automatic logic [7:0] low_byte(input logic [2:0] lv,
                                          input int unsigned src,
                                          input logic [7:0] busv);
    return (src == 0) ? busv : {lv, src_code(src)};
  endfunction
endpackage

// File: rtl/vag_regs.sv
`timescale 1ns/1ps
module vag_regs
  import vag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       page_wr,
  input  logic [7:0] page_wdata,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  output logic [7:0] page_q,
  output logic [2:0] lv_q,
  output logic [EXT_N-1:0] ext_en_q,
  output logic [7:0] io_rdata
);
  logic wr_lowvec, wr_ctrl;
  assign wr_lowvec = io_wr && (io_addr == IO_LOWVEC);
  assign wr_ctrl   = io_wr && (io_addr == IO_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      lv_q     <= '0;
      ext_en_q <= CTRL_RST;
    end else begin
      if (page_wr)   page_q   <= page_wdata;
      if (wr_lowvec) lv_q     <= io_wdata[7:5];
      if (wr_ctrl)   ext_en_q <= io_wdata[EXT_N-1:0];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      case (io_addr)
        IO_LOWVEC: io_rdata = {lv_q, 5'b0};
        IO_CTRL:   io_rdata = {{(8-EXT_N){1'b0}}, ext_en_q};
        default:   io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vag_arbiter.sv
`timescale 1ns/1ps
module vag_arbiter #(
  parameter int NSRC = 7,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [IW-1:0]   win_idx,
  output logic [NSRC-1:0] win_oh
);
  // Lowest index has highest priority: scan downward, last hit wins.
  always_comb begin
    win_idx = '0;
    win_oh  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_idx   = IW'(i);
        win_oh    = '0;
        win_oh[i] = 1'b1;
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/vag_addr_out.sv
`timescale 1ns/1ps
module vag_addr_out
  import vag_pkg::*;
#(
  parameter int NSRC = 7,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [7:0]      page,
  input  logic [2:0]      lv,
  input  logic [IW-1:0]   win_idx,
  input  logic [NSRC-1:0] win_oh,
  input  logic [7:0]      bus_vec,
  output logic [15:0]     vec_addr,
  output logic            vec_valid,
  output logic [NSRC-1:0] ack_oh
);
  logic [7:0] lo_next;
  assign lo_next = low_byte(lv, 32'(win_idx), bus_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_addr  <= '0;
      vec_valid <= 1'b0;
      ack_oh    <= '0;
    end else begin
      vec_valid <= fire;
      ack_oh    <= fire ? win_oh : '0;
      if (fire) vec_addr <= {page, lo_next};
    end
  end
endmodule

// File: rtl/vec_addr_gen.sv
`timescale 1ns/1ps
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int N_INT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_wr,
  input  logic [7:0]       page_wdata,
  output logic [7:0]       page_rdata,
  input  logic [7:0]       io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic             gie,
  input  logic [2:0]       irq_ext,
  input  logic [N_INT-1:0] irq_int,
  output logic             int_req,
  input  logic             ack_req,
  input  logic [7:0]       bus_vec,
  output logic [15:0]      vec_addr,
  output logic             vec_valid,
  output logic [2:0]       src_ack_ext,
  output logic [N_INT-1:0] src_ack_int
);
  localparam int NSRC = EXT_N + N_INT;
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;

  // Named internal events for the checker.
  logic [7:0]      page_q;
  logic [2:0]      lv_q;
  logic [EXT_N-1:0] ext_en_q;
  logic [NSRC-1:0] req_masked;
  logic [NSRC-1:0] win_oh;
  logic [IW-1:0]   win_idx;
  logic            any_req;
  logic            ack_fire;
  logic [NSRC-1:0] ack_oh;

  vag_regs u_regs (
    .clk, .rst_n, .page_wr, .page_wdata, .io_addr, .io_wr, .io_rd, .io_wdata,
    .page_q, .lv_q, .ext_en_q, .io_rdata
  );

  for (genvar e = 0; e < EXT_N; e++) begin : g_ext
    assign req_masked[e] = gie && ext_en_q[e] && irq_ext[e];
  end
  for (genvar k = 0; k < N_INT; k++) begin : g_int
    assign req_masked[EXT_N+k] = gie && irq_int[k];
  end

  vag_arbiter #(.NSRC(NSRC)) u_arb (
    .req(req_masked), .any(any_req), .win_idx, .win_oh
  );

  assign ack_fire = ack_req && any_req;

  vag_addr_out #(.NSRC(NSRC)) u_out (
    .clk, .rst_n, .fire(ack_fire), .page(page_q), .lv(lv_q),
    .win_idx, .win_oh, .bus_vec, .vec_addr, .vec_valid, .ack_oh
  );

  assign page_rdata  = page_q;
  assign int_req     = any_req;
  assign src_ack_ext = ack_oh[EXT_N-1:0];
  assign src_ack_int = ack_oh[NSRC-1:EXT_N];
endmodule

// File: rtl/vag_checker.sv
`timescale 1ns/1ps
module vag_checker #(
  parameter int N_INT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             ack_req,
  input logic             int_req,
  input logic [7:0]       bus_vec,
  input logic [7:0]       page_rdata,
  input logic [15:0]      vec_addr,
  input logic             vec_valid,
  input logic [2:0]       src_ack_ext,
  input logic [N_INT-1:0] src_ack_int
);
  AST_FIRE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && int_req) |=> vec_valid); // R6
  AST_NO_FIRE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_req && int_req) |=> !vec_valid); // R10
  AST_HIGH_BYTE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[15:8] == $past(page_rdata))); // R6
  AST_BUS_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && src_ack_ext[0]) |-> (vec_addr[7:0] == $past(bus_vec))); // R7
  AST_EVEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !src_ack_ext[0]) |-> !vec_addr[0]); // R8
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($countones({src_ack_int, src_ack_ext}) == 1)); // R10
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> ({src_ack_int, src_ack_ext} == '0)); // R10
  AST_GIE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !int_req); // R11
endmodule

bind vec_addr_gen vag_checker #(.N_INT(N_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack_req(ack_req), .int_req(int_req),
  .bus_vec(bus_vec), .page_rdata(page_rdata), .vec_addr(vec_addr),
  .vec_valid(vec_valid), .src_ack_ext(src_ack_ext), .src_ack_int(src_ack_int)
);

// File: tb/test_vec_addr_gen.sv
`timescale 1ns/1ps
module test_vec_addr_gen;
  localparam int N_INT = 4;
  localparam int NSRC  = 3 + N_INT;

  logic clk = 0, rst_n = 0;
  logic page_wr = 0, io_wr = 0, io_rd = 0, gie = 0, ack_req = 0;
  logic [7:0] page_wdata = '0, io_addr = '0, io_wdata = '0, bus_vec = '0;
  logic [2:0] irq_ext = '0;
  logic [N_INT-1:0] irq_int = '0;
  logic [7:0] page_rdata, io_rdata;
  logic int_req, vec_valid;
  logic [15:0] vec_addr;
  logic [2:0] src_ack_ext;
  logic [N_INT-1:0] src_ack_int;

  always #2 clk = ~clk; // 250 MHz

  vec_addr_gen #(.N_INT(N_INT)) i_vec_addr_gen (.*);

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side model of the programmable state.
  logic [7:0] m_page = 8'h00;
  logic [2:0] m_lv   = 3'b000;
  logic [2:0] m_en   = 3'b001;

  typedef struct {
    int              due;
    logic            v;
    logic [15:0]     a;
    logic [NSRC-1:0] k;
    string           tag;
  } item_t;
  item_t q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered outputs with the queue head when it is due.
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, " valid"}, 32'(vec_valid), 32'(it.v));
        chk({it.tag, " ack"}, 32'({src_ack_int, src_ack_ext}), 32'(it.k));
        if (it.v) chk({it.tag, " addr"}, 32'(vec_addr), 32'(it.a));
      end else if (vec_valid) begin
        chk("R10 unexpected valid", 32'(vec_valid), 32'd0);
      end
    end
  end

  // Driver: raise requests, check int_req, acknowledge and queue the expectation.
  task automatic do_ack(input logic [2:0] ext, input logic [N_INT-1:0] in,
                        input logic g, input logic [7:0] bv, input string tag);
    item_t it;
    logic [NSRC-1:0] en_req;
    int win;
    @(negedge clk);
    irq_ext = ext; irq_int = in; gie = g; bus_vec = bv;
    for (int e = 0; e < 3; e++) en_req[e] = g & m_en[e] & ext[e];
    for (int j = 0; j < N_INT; j++) en_req[3+j] = g & in[j];
    win = -1;
    for (int s = 0; s < NSRC; s++) if (win < 0 && en_req[s]) win = s;
    #1 chk({tag, " R5 int_req"}, 32'(int_req), 32'(en_req != 0));
    ack_req = 1;
    it.due = cyc + 1;
    it.tag = tag;
    it.v   = (win >= 0);
    it.k   = '0;
    it.a   = '0;
    if (win >= 0) begin
      it.k[win] = 1'b1;
      if (win == 0)      it.a = {m_page, bv};
      else if (win == 1) it.a = {m_page, m_lv, 5'd0};
      else if (win == 2) it.a = {m_page, m_lv, 5'd2};
      else               it.a = {m_page, m_lv, 5'(2*(win-3)+4)};
    end
    q.push_back(it);
    @(negedge clk);
    ack_req = 0; irq_ext = '0; irq_int = '0;
  endtask

  task automatic page_write(input logic [7:0] v);
    @(negedge clk); page_wr = 1; page_wdata = v;
    @(negedge clk); page_wr = 0; m_page = v;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = v;
    @(negedge clk); io_wr = 0;
    if (a == 8'h33) m_lv = v[7:5];
    if (a == 8'h34) m_en = v[2:0];
  endtask

  task automatic io_read(input logic [7:0] a, input string tag);
    logic [7:0] e;
    e = (a == 8'h33) ? {m_lv, 5'b0} : (a == 8'h34) ? {5'b0, m_en} : 8'h00;
    @(negedge clk); io_rd = 1; io_addr = a;
    #1 chk(tag, 32'(io_rdata), 32'(e));
    io_rd = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 page", 32'(page_rdata), 32'h00);
    chk("R1 valid", 32'(vec_valid), 32'd0);
    chk("R1 acks", 32'({src_ack_int, src_ack_ext}), 32'd0);
    io_read(8'h33, "R1 lowvec read");
    io_read(8'h34, "R1 ctrl read");
    // R2 page strobe, unaffected by I/O writes
    page_write(8'hA5);
    chk("R2 page load", 32'(page_rdata), 32'hA5);
    io_write(8'h00, 8'h3C);
    io_write(8'h33, 8'h00);
    chk("R2 page kept after io", 32'(page_rdata), 32'hA5);
    // R3 low-vector register
    io_write(8'h33, 8'hFF);
    io_read(8'h33, "R3 lowvec FF");
    io_write(8'h33, 8'h5F);
    io_read(8'h33, "R3 lowvec 5F");
    // R4 control register, other addresses ignored
    io_write(8'h34, 8'hFF);
    io_read(8'h34, "R4 ctrl FF");
    io_write(8'h35, 8'h00);
    io_write(8'h13, 8'h00);
    io_read(8'h33, "R4 lowvec untouched");
    io_read(8'h34, "R4 ctrl untouched");
    io_read(8'h35, "R4 other reads zero");
    // Set up for vectoring
    io_write(8'h33, 8'hA0);
    page_write(8'h12);
    do_ack(3'b001, 4'b0000, 1, 8'h3C, "R7 ext0 bus vector");
    do_ack(3'b111, 4'b1111, 1, 8'h5A, "R9 ext0 over all");
    do_ack(3'b110, 4'b1111, 1, 8'h00, "R8 R9 ext1 code");
    do_ack(3'b100, 4'b1111, 1, 8'h00, "R8 R9 ext2 code");
    do_ack(3'b000, 4'b1010, 1, 8'h00, "R9 int1 over int3");
    do_ack(3'b000, 4'b1000, 1, 8'h00, "R8 int3 code");
    do_ack(3'b000, 4'b0001, 1, 8'hFF, "R8 int0 code");
    do_ack(3'b111, 4'b1111, 0, 8'h77, "R11 gie low");
    do_ack(3'b000, 4'b0000, 1, 8'h77, "R10 ack with nothing");
    // Mask external lines
    io_write(8'h34, 8'h00);
    do_ack(3'b111, 4'b0000, 1, 8'h11, "R11 ext masked");
    do_ack(3'b111, 4'b0100, 1, 8'h11, "R11 int wins over masked ext");
    io_write(8'h34, 8'h04);
    do_ack(3'b111, 4'b0001, 1, 8'h11, "R11 only ext2 enabled");
    // Page move and a different low-vector field
    page_write(8'hFE);
    io_write(8'h33, 8'h7F);
    do_ack(3'b100, 4'b0000, 1, 8'h00, "R6 new page ext2");
    io_write(8'h34, 8'h01);
    do_ack(3'b001, 4'b0000, 1, 8'hC3, "R6 R7 new page ext0");
    // Back-to-back acknowledges, checking single-cycle valid
    do_ack(3'b000, 4'b0010, 1, 8'h00, "R6 back to back a");
    do_ack(3'b000, 4'b0100, 1, 8'h00, "R6 back to back b");
    repeat (3) @(negedge clk);
    chk("R6 valid drops", 32'(vec_valid), 32'd0);
    chk("R10 queue drained", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule